// File: doc/BRIEF.md
# Size-Masked Base Address Decoder

This block holds the address window registers of one configuration-space function: six 32-bit base registers, one expansion ROM register and the 16-bit command register. Each window has a power-of-two size and a space type (I/O or memory), both fixed by parameters. A configuration write to a window register keeps only the base bits above the window size. This lets software size a window by writing all ones and reading back the mask. The ROM register also keeps bit 0, which enables ROM decoding.

Decode state is kept per window as a mapped flag, a base and a last address. A small state machine rebuilds this state after every write that changes a window register or the command register. It has two states. ST_IDLE holds the decode state. ST_SCAN visits the windows one per cycle, in index order 0 to 6, and recomputes each one with a single shared evaluator. The transitions are:

- idle-to-scan: taken on a qualifying write.
- scan-step: moves to the next index.
- scan-to-idle: taken after index 6.
- scan-restart: a qualifying write during a scan begins again at index 0.

Incoming requests carry a space type and an address. The block answers one cycle later with a per-window hit vector and the offset into the lowest-numbered hit window.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset the command register, all six base registers and the ROM register read as zero, no window is mapped and no request hits.
- R2: Registers sit at dword offsets 0x04 (command), 0x10 + 4*n for base register n = 0..5, and 0x30 (ROM). A write with all four byte enables set to a base register stores the data ANDed with the inverse of (size - 1). Writing all ones therefore reads back the size mask.
- R3: A full write to the ROM register stores the size-aligned base bits plus bit 0, the ROM decode enable.
- R4: A write to a base or ROM offset with any byte enable clear leaves that register unchanged.
- R5: I/O windows are mapped only while command bit 0 is 1. Memory windows, the ROM included, are mapped only while command bit 1 is 1.
- R6: The ROM window is mapped only while its bit 0 is 1.
- R7: A window whose aligned base is zero is never mapped.
- R8: A window is unmapped if base + size - 1 overflows 32 bits. The highest aligned window, whose last address is 0xFFFFFFFF, is still mapped.
- R9: An I/O window whose last address is 0x10000 or higher is unmapped.
- R10: A request hits window i when the window is mapped, req_is_io equals the window's type, and base <= address <= last. The hit vector (bit i = window i, bit 6 = ROM) and the offset, address minus the base of the lowest-numbered hit window (0 if no hit), appear on the clock edge after the request.
- R11: A write touching command bytes 0 or 1, or a full write to a window register, starts a scan. Window i takes its new state on the (i+1)-th edge after the write edge. A write during a scan restarts it at window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Byte offset of the dword written (bits 1:0 ignored) |
| cfg_wr_be | input | 4 | Byte enables of the write |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_addr | input | 8 | Byte offset of the dword read |
| cfg_rd_data | output | 32 | Combinational read data |
| req_valid | input | 1 | Address request present |
| req_is_io | input | 1 | 1 = I/O space request, 0 = memory space |
| req_addr | input | 32 | Request address |
| hit_vec | output | 7 | Registered per-window hit flags |
| hit_offset | output | 32 | Registered offset into the lowest hit window |
| region_mapped | output | 7 | Per-window mapped flags |

## Verification
The bench uses the default sizes: a 16-byte I/O window, a 4 KiB, a 1 MiB, a 256-byte I/O, a 16-byte and a 64 KiB memory window, and a 64 KiB ROM.

The small I/O sizes let the bench place windows directly at the 64 KiB I/O boundary, once just below it and once just above. The 64 KiB memory window can sit at the very top of the address space to probe the overflow rule. Leaving the 16-byte window at zero keeps one unmapped window in every table walk.

The 4 KiB window also shows the sizing readback.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;
    localparam int unsigned NUM_REGIONS = 7;
    localparam int unsigned ROM_IDX     = 6;
    localparam int unsigned IDX_W       = $clog2(NUM_REGIONS);
    localparam int unsigned CMD_DW      = 1;   // byte offset 0x04
    localparam int unsigned BAR_DW      = 4;   // byte offset 0x10
    localparam int unsigned ROM_DW      = 12;  // byte offset 0x30
    localparam logic [32:0] IO_LIMIT    = 33'h0_0001_0000;

    typedef logic [31:0] word_t;
    typedef enum logic { ST_IDLE, ST_SCAN } scan_state_e;

    function automatic word_t span_mask(input logic [4:0] lg);
        return (word_t'(1) << lg) - word_t'(1);
    endfunction

    function automatic int unsigned region_dword(input int unsigned i);
        return (i == ROM_IDX) ? ROM_DW : (BAR_DW + i);
    endfunction
endpackage

// File: rtl/bar_cfg_regs.sv
module bar_cfg_regs
    import bar_dec_pkg::*;
#(
    parameter int unsigned CFG_AW = 8,
    parameter logic [NUM_REGIONS-1:0][4:0] SIZE_LOG2 = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic [CFG_AW-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [15:0]       cmd_q,
    output word_t             region_q [NUM_REGIONS],
    output logic              reval
);
    localparam int unsigned DW_W = CFG_AW - 2;

    logic [DW_W-1:0] wr_dw, rd_dw;
    logic            full_wr, cmd_touch;
    logic [NUM_REGIONS-1:0] region_sel;

    assign wr_dw     = wr_addr[CFG_AW-1:2];
    assign rd_dw     = rd_addr[CFG_AW-1:2];
    assign full_wr   = (wr_be == 4'hF);
    assign cmd_touch = wr_en && (32'(wr_dw) == CMD_DW) && (|wr_be[1:0]);
    assign reval     = cmd_touch || (wr_en && full_wr && (|region_sel));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_en && (32'(wr_dw) == CMD_DW)) begin
            if (wr_be[0]) cmd_q[7:0]  <= wr_data[7:0];
            if (wr_be[1]) cmd_q[15:8] <= wr_data[15:8];
        end
    end

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_reg
        localparam word_t KEEP = ~span_mask(SIZE_LOG2[i]) |
                                 ((i == ROM_IDX) ? word_t'(1) : word_t'(0));
        assign region_sel[i] = (32'(wr_dw) == region_dword(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                region_q[i] <= '0;
            end else if (wr_en && region_sel[i] && full_wr) begin
                region_q[i] <= wr_data & KEEP;
            end
        end

        // R4
        partial_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && region_sel[i] && !full_wr) |=> $stable(region_q[i]));

        // R2
        if (i != ROM_IDX) begin : g_align
            bar_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && region_sel[i] && full_wr) |=>
                    ((region_q[i] & span_mask(SIZE_LOG2[i])) == '0));
        end
    end

    always_comb begin
        rd_data = '0;
        if (32'(rd_dw) == CMD_DW) rd_data = {16'h0, cmd_q};
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (32'(rd_dw) == region_dword(i)) rd_data = region_q[i];
        end
    end
endmodule

// File: rtl/bar_scan_fsm.sv
module bar_scan_fsm
    import bar_dec_pkg::*;
#(
    parameter logic [NUM_REGIONS-1:0][4:0] SIZE_LOG2 = '0,
    parameter logic [NUM_REGIONS-1:0]      IO_VEC    = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reval,
    input  logic [15:0]            cmd,
    input  word_t                  region_word [NUM_REGIONS],
    output logic [NUM_REGIONS-1:0] mapped,
    output word_t                  base [NUM_REGIONS],
    output word_t                  last [NUM_REGIONS]
);
    scan_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // shared evaluator for the window under the scan pointer
    word_t       cur_word, cur_mask, cand_base;
    logic [32:0] cand_sum;
    logic        cur_io, cur_rom, space_en, rom_ok, io_ok, cand_ok;

    always_comb begin
        cur_word  = region_word[idx_q];
        cur_mask  = span_mask(SIZE_LOG2[idx_q]);
        cur_io    = IO_VEC[idx_q];
        cur_rom   = (32'(idx_q) == ROM_IDX);
        cand_base = cur_word & ~cur_mask;
        cand_sum  = {1'b0, cand_base} + {1'b0, cur_mask};
        space_en  = cur_io ? cmd[0] : cmd[1];
        rom_ok    = !cur_rom || cur_word[0];
        io_ok     = !cur_io || (cand_sum < IO_LIMIT);
        cand_ok   = space_en && rom_ok && io_ok &&
                    (cand_base != '0) && !cand_sum[32];
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (reval) begin
                    state_d = ST_SCAN;
                    idx_d   = '0;
                end
            end
            ST_SCAN: begin
                if (reval) begin
                    idx_d = '0;
                end else if (32'(idx_q) == NUM_REGIONS - 1) begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mapped <= '0;
            for (int i = 0; i < NUM_REGIONS; i++) begin
                base[i] <= '0;
                last[i] <= '0;
            end
        end else if (state_q == ST_SCAN) begin
            mapped[idx_q] <= cand_ok;
            base[idx_q]   <= cand_base;
            last[idx_q]   <= cand_sum[31:0];
        end
    end

    // R11
    scan_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (32'(idx_q) < NUM_REGIONS));

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_chk
        // R7
        zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mapped[i] |-> (base[i] != '0));
        // R8
        no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mapped[i] |-> (last[i] >= base[i]));
        // R9
        if (IO_VEC[i]) begin : g_io
            io_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                mapped[i] |-> ({1'b0, last[i]} < IO_LIMIT));
        end
        // R5
        enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_IDLE && !reval && mapped[i]) |->
                (IO_VEC[i] ? cmd[0] : cmd[1]));
    end
endmodule

// File: rtl/bar_match.sv
module bar_match
    import bar_dec_pkg::*;
#(
    parameter logic [NUM_REGIONS-1:0] IO_VEC = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_is_io,
    input  word_t                  req_addr,
    input  logic [NUM_REGIONS-1:0] mapped,
    input  word_t                  base [NUM_REGIONS],
    input  word_t                  last [NUM_REGIONS],
    output logic [NUM_REGIONS-1:0] hit_q,
    output word_t                  offset_q
);
    logic [NUM_REGIONS-1:0] hit_d;
    word_t                  offset_d;

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
        assign hit_d[i] = req_valid && mapped[i] && (req_is_io == IO_VEC[i]) &&
                          (req_addr >= base[i]) && (req_addr <= last[i]);
    end

    always_comb begin
        offset_d = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit_d[i]) offset_d = req_addr - base[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q    <= '0;
            offset_q <= '0;
        end else begin
            hit_q    <= hit_d;
            offset_q <= offset_d;
        end
    end

    // R10
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q != '0) |-> $past(req_valid));
    // R10
    miss_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q == '0) |-> (offset_q == '0));
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
    import bar_dec_pkg::*;
#(
    parameter int unsigned CFG_AW = 8,
    parameter logic [NUM_REGIONS-1:0][4:0] SIZE_LOG2 =
        {5'd16, 5'd16, 5'd4, 5'd8, 5'd20, 5'd12, 5'd4},
    parameter logic [NUM_REGIONS-2:0] BAR_IS_IO = 6'b001001
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_en,
    input  logic [CFG_AW-1:0]      cfg_wr_addr,
    input  logic [3:0]             cfg_wr_be,
    input  logic [31:0]            cfg_wr_data,
    input  logic [CFG_AW-1:0]      cfg_rd_addr,
    output logic [31:0]            cfg_rd_data,
    input  logic                   req_valid,
    input  logic                   req_is_io,
    input  logic [31:0]            req_addr,
    output logic [NUM_REGIONS-1:0] hit_vec,
    output logic [31:0]            hit_offset,
    output logic [NUM_REGIONS-1:0] region_mapped
);
    localparam logic [NUM_REGIONS-1:0] IO_VEC = {1'b0, BAR_IS_IO};

    logic [15:0] cmd_q;
    logic        reval;
    word_t       region_q [NUM_REGIONS];
    word_t       dec_base [NUM_REGIONS];
    word_t       dec_last [NUM_REGIONS];

    bar_cfg_regs #(.CFG_AW(CFG_AW), .SIZE_LOG2(SIZE_LOG2)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_be(cfg_wr_be),
        .wr_data(cfg_wr_data), .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
        .cmd_q(cmd_q), .region_q(region_q), .reval(reval)
    );

    bar_scan_fsm #(.SIZE_LOG2(SIZE_LOG2), .IO_VEC(IO_VEC)) u_scan (
        .clk(clk), .rst_n(rst_n), .reval(reval), .cmd(cmd_q),
        .region_word(region_q), .mapped(region_mapped),
        .base(dec_base), .last(dec_last)
    );

    bar_match #(.IO_VEC(IO_VEC)) u_match (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
        .req_addr(req_addr), .mapped(region_mapped), .base(dec_base),
        .last(dec_last), .hit_q(hit_vec), .offset_q(hit_offset)
    );
endmodule

// File: tb/sim_bar_window_decoder.sv
module sim_bar_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [3:0]  cfg_wr_be = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [7:0]  cfg_rd_addr = '0;
    logic [31:0] cfg_rd_data;
    logic        req_valid = 1'b0;
    logic        req_is_io = 1'b0;
    logic [31:0] req_addr = '0;
    logic [6:0]  hit_vec;
    logic [31:0] hit_offset;
    logic [6:0]  region_mapped;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    bar_window_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_be(cfg_wr_be), .cfg_wr_data(cfg_wr_data), .cfg_rd_addr(cfg_rd_addr),
        .cfg_rd_data(cfg_rd_data), .req_valid(req_valid), .req_is_io(req_is_io),
        .req_addr(req_addr), .hit_vec(hit_vec), .hit_offset(hit_offset),
        .region_mapped(region_mapped)
    );

    // {is_io, addr, expected hit vector, expected offset}
    localparam logic [71:0] VECS [12] = '{
        {1'b1, 32'h0000_C000, 7'b0000001, 32'h0000_0000},
        {1'b1, 32'h0000_C00F, 7'b0000001, 32'h0000_000F},
        {1'b1, 32'h0000_C010, 7'b0000000, 32'h0000_0000},
        {1'b0, 32'h0000_C000, 7'b0000000, 32'h0000_0000},
        {1'b0, 32'hF000_0FFF, 7'b0000010, 32'h0000_0FFF},
        {1'b0, 32'hF000_1000, 7'b0000000, 32'h0000_0000},
        {1'b0, 32'hF01A_BCDE, 7'b0000100, 32'h000A_BCDE},
        {1'b1, 32'h0000_C1FF, 7'b0001000, 32'h0000_00FF},
        {1'b0, 32'hF020_1234, 7'b0100000, 32'h0000_1234},
        {1'b0, 32'hF030_8000, 7'b1000000, 32'h0000_8000},
        {1'b0, 32'h0000_0000, 7'b0000000, 32'h0000_0000},
        {1'b1, 32'h0000_BFFF, 7'b0000000, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_be = be; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic wr_settle(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        wr(a, be, d);
        repeat (8) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        cfg_rd_addr = a;
        #1;
        d = cfg_rd_data;
    endtask

    task automatic probe(input logic io, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_is_io = io; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h04, d); chk("R1 cmd after reset", d, 0);
        for (int i = 0; i < 6; i++) begin
            rd(8'h10 + 8'(4 * i), d); chk("R1 bar after reset", d, 0);
        end
        rd(8'h30, d); chk("R1 rom after reset", d, 0);
        chk("R1 mapped after reset", 32'(region_mapped), 0);
        probe(1'b0, 32'hF000_0000); chk("R1 no hit after reset", 32'(hit_vec), 0);

        // configure
        wr_settle(8'h04, 4'b0011, 32'h0000_0003);
        wr_settle(8'h10, 4'hF, 32'h0000_C00F);
        rd(8'h10, d); chk("R2 io bar masked", d, 32'h0000_C000);
        wr_settle(8'h14, 4'hF, 32'hFFFF_FFFF);
        rd(8'h14, d); chk("R2 sizing readback", d, 32'hFFFF_F000);
        wr_settle(8'h14, 4'hF, 32'hF000_0000);
        wr_settle(8'h18, 4'hF, 32'hF010_0000);
        wr_settle(8'h1C, 4'hF, 32'h0000_C100);
        wr_settle(8'h24, 4'hF, 32'hF020_0000);
        wr_settle(8'h30, 4'hF, 32'hF030_ABCD);
        rd(8'h30, d); chk("R3 rom keeps enable bit", d, 32'hF030_0001);
        chk("R7 mapped set with zero base window", 32'(region_mapped), 32'h6F);

        // R10 table walk
        for (int k = 0; k < 12; k++) begin
            probe(VECS[k][71], VECS[k][70:39]);
            chk("R10 hit vector", 32'(hit_vec), 32'(VECS[k][38:32]));
            chk("R10 hit offset", hit_offset, VECS[k][31:0]);
        end

        // R4 partial write ignored
        wr_settle(8'h10, 4'b0001, 32'h0000_00FF);
        rd(8'h10, d); chk("R4 byte write ignored", d, 32'h0000_C000);
        wr_settle(8'h30, 4'b0111, 32'h0000_0000);
        rd(8'h30, d); chk("R4 rom partial write ignored", d, 32'hF030_0001);
        probe(1'b1, 32'h0000_C004); chk("R4 window still decodes", 32'(hit_vec), 32'h01);

        // R5 command enables
        wr_settle(8'h04, 4'b0001, 32'h0000_0002);
        probe(1'b1, 32'h0000_C000); chk("R5 io off", 32'(hit_vec), 0);
        probe(1'b0, 32'hF000_0000); chk("R5 mem on", 32'(hit_vec), 32'h02);
        wr_settle(8'h04, 4'b0001, 32'h0000_0001);
        probe(1'b0, 32'hF000_0000); chk("R5 mem off", 32'(hit_vec), 0);
        probe(1'b0, 32'hF030_0000); chk("R5 rom off with mem off", 32'(hit_vec), 0);
        probe(1'b1, 32'h0000_C000); chk("R5 io on", 32'(hit_vec), 32'h01);
        wr_settle(8'h04, 4'b0001, 32'h0000_0003);

        // R6 ROM enable bit
        wr_settle(8'h30, 4'hF, 32'hF030_0000);
        chk("R6 rom unmapped", 32'(region_mapped[6]), 0);
        probe(1'b0, 32'hF030_8000); chk("R6 rom no hit", 32'(hit_vec), 0);
        wr_settle(8'h30, 4'hF, 32'hF030_0001);
        chk("R6 rom mapped again", 32'(region_mapped[6]), 1);

        // R7 zero base
        wr_settle(8'h10, 4'hF, 32'h0000_0000);
        chk("R7 zero base unmapped", 32'(region_mapped[0]), 0);
        probe(1'b1, 32'h0000_0000); chk("R7 zero base no hit", 32'(hit_vec), 0);

        // R11 scan timing for window 0
        wr(8'h10, 4'hF, 32'h0000_C000);
        req_valid = 1'b1; req_is_io = 1'b1; req_addr = 32'h0000_C000;
        @(negedge clk); chk("R11 window0 not yet updated", 32'(hit_vec), 0);
        @(negedge clk); chk("R11 window0 updated next edge", 32'(hit_vec), 32'h01);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);

        // R9 I/O limit
        wr_settle(8'h1C, 4'hF, 32'h0001_0000);
        chk("R9 io above 64K unmapped", 32'(region_mapped[3]), 0);
        probe(1'b1, 32'h0001_0000); chk("R9 io above 64K no hit", 32'(hit_vec), 0);
        wr_settle(8'h1C, 4'hF, 32'h0000_FF00);
        probe(1'b1, 32'h0000_FFFF); chk("R9 io at top of 64K hits", 32'(hit_vec), 32'h08);
        chk("R9 io top offset", hit_offset, 32'h0000_00FF);

        // R8 top of address space
        wr_settle(8'h24, 4'hF, 32'hFFFF_0000);
        chk("R8 top window mapped", 32'(region_mapped[5]), 1);
        probe(1'b0, 32'hFFFF_FFFF); chk("R8 top window hit", 32'(hit_vec), 32'h20);
        chk("R8 top window offset", hit_offset, 32'h0000_FFFF);

        finish_run();
    end
endmodule